// File: doc/BRIEF.md
# Control-Flow Timing Watchdog

This block supervises the control flow of a program as a timed state machine. Software reports each high-level step it enters by presenting a step identifier on a checkpoint port. The monitor holds a table with one entry per step: a mask of the steps allowed to follow it, and the shortest and longest gaps allowed before the next checkpoint. Three kinds of fault are reported:

- A jump to a step that is not an allowed successor.
- A checkpoint that comes before the shortest allowed gap.
- A step that is never left: no checkpoint arrives before the longest allowed gap runs out.

The table is loaded while the monitor is disabled. After reset, after a clear, and after each disable, the monitor waits for a fixed initial step. The first fault is latched into its own sticky flag and the monitor stops tracking. It stays stopped until software clears the flags.

Gaps are counted in clock edges. The edge that accepts a checkpoint is gap 0. A checkpoint sampled k rising edges later has gap k.

Top module: `cfw_monitor`

## Requirements
- R1: After reset, all three error flags are 0, `cur_state` equals the initial step (INIT_ID, default 0), and the monitor is waiting for its first checkpoint.
- R2: While waiting, a checkpoint carrying INIT_ID is accepted and starts gap counting. A checkpoint carrying any other identifier sets `err_seq`.
- R3: Once running, a checkpoint sets `err_seq` when bit `cp_id` of the current step's successor mask is 0. Bit j of the mask allows step j to follow.
- R4: A legal successor whose gap is below the current step's minimum sets `err_early`. When a checkpoint is both illegal and early, only `err_seq` is set.
- R5: A legal successor whose gap is at least the minimum and at most the maximum is accepted. `cur_state` shows the new step after the accepting edge. Without an accepted checkpoint, `cur_state` does not change.
- R6: When the gap reaches the current step's maximum and no checkpoint is present on that edge, `err_starve` is set.
- R7: Error flags are sticky. At most one flag is set at a time. After a flag is set, checkpoints and elapsed time have no effect: `cur_state` holds and no further flag is set.
- R8: A one-cycle `clr_err` pulse clears all flags, sets `cur_state` to INIT_ID and returns the monitor to waiting for INIT_ID.
- R9: A table write (`cfg_we`) lands only while `enable` is 0. A write while `enable` is 1 is ignored.
- R10: While `enable` is 0, no flag is set and no time is counted. When `enable` returns to 1, the monitor waits for INIT_ID again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Monitor running; table writable when 0 |
| cfg_we | input | 1 | Table write strobe |
| cfg_idx | input | ID_W | Table entry to write |
| cfg_succ | input | NUM_STATES | Successor mask for the entry |
| cfg_min | input | CNT_W | Minimum gap for the entry |
| cfg_max | input | CNT_W | Maximum gap for the entry (at least 1) |
| cp_valid | input | 1 | Checkpoint present |
| cp_id | input | ID_W | Identifier of the step being entered |
| clr_err | input | 1 | Clear flags and restart |
| cur_state | output | ID_W | Step currently tracked |
| err_seq | output | 1 | Sticky illegal-sequence flag |
| err_early | output | 1 | Sticky early-transition flag |
| err_starve | output | 1 | Sticky starvation flag |

## Verification
The bench probes the exact edges of the timing window: a checkpoint exactly at the maximum gap must be accepted, and silence one edge past the last allowed point must raise starvation. A design off by one in either direction would either reject the legal boundary checkpoint or report starvation one cycle early or late. Further tests cover the following:

- A checkpoint that is both illegal and early, which must report only the sequence fault. A design with the wrong priority would raise the early flag.
- Keeping state after a fault. A design that does not freeze would move `cur_state` or stack a second flag.
- Table writes while enabled, which must be ignored.
- Re-enabling after a disable, which must require the initial step again. A design that kept counting while disabled would report starvation.

// File: rtl/cfw_monitor.sv
module cfw_monitor #(
  parameter int NUM_STATES = 8,
  parameter int CNT_W      = 16,
  parameter int INIT_ID    = 0,
  localparam int ID_W      = (NUM_STATES > 1) ? $clog2(NUM_STATES) : 1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  enable,
  input  logic                  cfg_we,
  input  logic [ID_W-1:0]       cfg_idx,
  input  logic [NUM_STATES-1:0] cfg_succ,
  input  logic [CNT_W-1:0]      cfg_min,
  input  logic [CNT_W-1:0]      cfg_max,
  input  logic                  cp_valid,
  input  logic [ID_W-1:0]       cp_id,
  input  logic                  clr_err,
  output logic [ID_W-1:0]       cur_state,
  output logic                  err_seq,
  output logic                  err_early,
  output logic                  err_starve
);

  localparam logic [ID_W-1:0] INIT = ID_W'(INIT_ID);

  logic [NUM_STATES-1:0] succ_tbl [NUM_STATES];
  logic [CNT_W-1:0]      min_tbl  [NUM_STATES];
  logic [CNT_W-1:0]      max_tbl  [NUM_STATES];
  logic [CNT_W-1:0]      dwell;
  logic                  started;

  wire frozen     = err_seq | err_early | err_starve;
  wire id_ok      = int'(cp_id) < NUM_STATES;
  wire legal      = id_ok && succ_tbl[cur_state][cp_id];
  wire too_early  = dwell < min_tbl[cur_state];
  wire starve_hit = dwell >= max_tbl[cur_state];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_STATES; i++) begin
        succ_tbl[i] <= '0;
        min_tbl[i]  <= '0;
        max_tbl[i]  <= '0;
      end
    end else if (cfg_we && !enable && int'(cfg_idx) < NUM_STATES) begin
      succ_tbl[cfg_idx] <= cfg_succ;
      min_tbl[cfg_idx]  <= cfg_min;
      max_tbl[cfg_idx]  <= cfg_max;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_state  <= INIT;
      started    <= 1'b0;
      dwell      <= '0;
      err_seq    <= 1'b0;
      err_early  <= 1'b0;
      err_starve <= 1'b0;
    end else if (clr_err) begin
      cur_state  <= INIT;
      started    <= 1'b0;
      dwell      <= '0;
      err_seq    <= 1'b0;
      err_early  <= 1'b0;
      err_starve <= 1'b0;
    end else if (!enable) begin
      started <= 1'b0;
      dwell   <= '0;
    end else if (!frozen) begin
      if (!started) begin
        if (cp_valid) begin
          if (cp_id == INIT) begin
            started   <= 1'b1;
            cur_state <= INIT;
            dwell     <= CNT_W'(1);
          end else begin
            err_seq <= 1'b1;
          end
        end
      end else if (cp_valid) begin
        if (!legal)          err_seq   <= 1'b1;
        else if (too_early)  err_early <= 1'b1;
        else begin
          cur_state <= cp_id;
          dwell     <= CNT_W'(1);
        end
      end else if (starve_hit) begin
        err_starve <= 1'b1;
      end else begin
        dwell <= dwell + CNT_W'(1);
      end
    end
  end

  a_r4_single_flag: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({err_seq, err_early, err_starve}));

  a_r5_no_move_without_cp: assert property (@(posedge clk) disable iff (!rst_n)
    (!cp_valid && !clr_err) |=> $stable(cur_state));

  a_r6_starve_on_silence: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_starve) |-> $past(!cp_valid));

  a_r7_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (frozen && !clr_err) |=> ($stable({err_seq, err_early, err_starve}) && $stable(cur_state)));

  a_r8_clear: assert property (@(posedge clk) disable iff (!rst_n)
    clr_err |=> (!err_seq && !err_early && !err_starve && cur_state == INIT));

  a_r10_quiet_when_off: assert property (@(posedge clk) disable iff (!rst_n)
    (!enable && !clr_err) |=> $stable({err_seq, err_early, err_starve}));

endmodule

// File: tb/test_cfw_monitor.sv
module test_cfw_monitor;
  localparam int N = 8;
  localparam int CW = 8;
  localparam int IW = 3;

  logic clk = 1'b0, rst_n = 1'b0, enable = 1'b0, cfg_we = 1'b0;
  logic [IW-1:0] cfg_idx = '0;
  logic [N-1:0] cfg_succ = '0;
  logic [CW-1:0] cfg_min = '0, cfg_max = '0;
  logic cp_valid = 1'b0;
  logic [IW-1:0] cp_id = '0;
  logic clr_err = 1'b0;
  logic [IW-1:0] cur_state;
  logic err_seq, err_early, err_starve;
  int checks = 0, fails = 0;

  always #5 clk = ~clk;

  cfw_monitor #(.NUM_STATES(N), .CNT_W(CW), .INIT_ID(0)) i_cfw_monitor (
    .clk(clk), .rst_n(rst_n), .enable(enable), .cfg_we(cfg_we), .cfg_idx(cfg_idx),
    .cfg_succ(cfg_succ), .cfg_min(cfg_min), .cfg_max(cfg_max), .cp_valid(cp_valid),
    .cp_id(cp_id), .clr_err(clr_err), .cur_state(cur_state), .err_seq(err_seq),
    .err_early(err_early), .err_starve(err_starve));

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic chk_flags(input string req, input int s, input int e, input int t);
    chk({req, " seq"}, int'(err_seq), s);
    chk({req, " early"}, int'(err_early), e);
    chk({req, " starve"}, int'(err_starve), t);
  endtask

  task automatic send(input int id);
    cp_valid = 1'b1; cp_id = IW'(id);
    @(negedge clk);
    cp_valid = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic prog(input int idx, input int succ, input int mn, input int mx);
    cfg_we = 1'b1; cfg_idx = IW'(idx); cfg_succ = N'(succ);
    cfg_min = CW'(mn); cfg_max = CW'(mx);
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic clear();
    clr_err = 1'b1;
    @(negedge clk);
    clr_err = 1'b0;
    chk_flags("R8 clear", 0, 0, 0);
    chk("R8 cur after clear", int'(cur_state), 0);
  endtask

  task automatic t_reset();
    chk_flags("R1 reset", 0, 0, 0);
    chk("R1 cur_state", int'(cur_state), 0);
  endtask

  task automatic t_bad_first();
    send(3);
    chk_flags("R2 wrong first id", 1, 0, 0);
    clear();
  endtask

  task automatic t_legal_walk();
    send(0);
    chk("R2 init accepted", int'(cur_state), 0);
    idle(1); send(1);
    chk("R5 step to 1", int'(cur_state), 1);
    send(2);
    chk("R5 step to 2", int'(cur_state), 2);
    idle(2); send(0);
    chk("R5 step to 0", int'(cur_state), 0);
    chk_flags("R5 legal walk", 0, 0, 0);
  endtask

  task automatic t_early();
    send(1);
    chk_flags("R4 early", 0, 1, 0);
    idle(3); send(1);
    chk("R7 frozen cur", int'(cur_state), 0);
    chk_flags("R7 no extra flag", 0, 1, 0);
    clear();
  endtask

  task automatic t_priority();
    send(0); send(2);
    chk_flags("R4 seq over early", 1, 0, 0);
    clear();
  endtask

  task automatic t_bad_successor();
    send(0); idle(2); send(5);
    chk_flags("R3 illegal successor", 1, 0, 0);
    clear();
  endtask

  task automatic t_starve();
    send(0); idle(4);
    chk_flags("R6 before limit", 0, 0, 0);
    idle(1);
    chk_flags("R6 starvation", 0, 0, 1);
    clear();
  endtask

  task automatic t_boundary();
    send(0); idle(4); send(1);
    chk("R5 accepted at max gap", int'(cur_state), 1);
    chk_flags("R5 max gap no flag", 0, 0, 0);
    idle(2);
    chk_flags("R6 state1 before limit", 0, 0, 0);
    idle(1);
    chk_flags("R6 state1 starvation", 0, 0, 1);
    idle(5); send(0);
    chk("R7 cur held", int'(cur_state), 1);
    chk_flags("R7 flags held", 0, 0, 1);
    clear();
  endtask

  task automatic t_cfg_locked();
    prog(0, 'hFF, 0, 200);
    send(0); idle(2); send(5);
    chk_flags("R9 write while enabled ignored", 1, 0, 0);
    clear();
  endtask

  task automatic t_disable();
    send(0);
    enable = 1'b0;
    idle(20);
    chk_flags("R10 no count while off", 0, 0, 0);
    enable = 1'b1;
    send(1);
    chk_flags("R10 re-enable waits for init", 1, 0, 0);
    clear();
  endtask

  initial begin
    #2_000_000;
    fails++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(1);
    t_reset();
    prog(0, 'h02, 2, 5);
    prog(1, 'h05, 1, 3);
    prog(2, 'h01, 3, 4);
    enable = 1'b1;
    idle(1);
    t_bad_first();
    t_legal_walk();
    t_early();
    t_priority();
    t_bad_successor();
    t_starve();
    t_boundary();
    t_cfg_locked();
    t_disable();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule